// File: doc/BRIEF.md
# Receive Channel Event Status and Interrupt Controller

This block holds the event status of one receive DMA channel and decides when that channel raises its interrupt. Twenty-two hardware event strobes are captured into sticky status bits. A per-event mask removes chosen events from interrupt and error reporting. A one-shot arm bit, kept inside the status word, lets exactly one interrupt through per arming. Events fall into two classes. Non-fatal events are acknowledged by a write-one-to-clear update. Fatal events stay latched until software requests a channel reset. That reset wipes all status and holds the channel quiet for a fixed number of cycles.

Software reaches the block through a small register port: one-cycle writes with an address, 64-bit data and a mode select (plain or write-one-to-clear), and reads whose data is returned one cycle after the request. Address 0 is the status word, address 1 the mask and address 2 the channel configuration. Writes to the mask and configuration take effect only in plain mode.

Top module: `rx_evt_intr_ctrl`

## Requirements
- R1: A 1 on event input i (for every i except 15) sets status bit i, which reads back at bit 32+i of address 0. It stays set until it is cleared. Input 15 has no effect. Read data appears on rd_data_o one cycle after rd_en_i. All bits outside 53:32 of address 0, outside 21:0 of address 1 and other than bit 30 of address 2 read as 0, and address 3 reads all zero.
- R2: Address 1 holds a 22-bit mask in bits 21:0. A status bit whose mask bit is 1 stays latched and readable, but it contributes to neither irq_o nor fatal_o.
- R3: Status bit 15 (data bit 47) is the arm bit. When it is 1 and at least one unmasked status bit other than 15 is set, irq_o goes high at the next clock edge and the arm bit clears at that same edge. irq_o then stays high until no unmasked bit other than 15 remains set, and falls one cycle after that happens.
- R4: After irq_o has fallen, new events do not raise it again until the arm bit is written to 1 again.
- R5: A write-one-to-clear (wr_w1c_i=1) to address 0 clears each non-fatal status bit 3, 7, 8, 9, 10, 13, 14 and 16 whose data bit 32+i is 1. Data bits that are 0 change nothing. Fatal bits and the arm bit are not affected.
- R6: If an event input is 1 in the same cycle as a write-one-to-clear of its bit, the bit stays set.
- R7: A plain write (wr_w1c_i=0) to address 0 loads the arm bit from data bit 47 and leaves all other status bits unchanged.
- R8: fatal_o is 1 while any unmasked status bit among 0, 1, 2, 4, 5, 6, 11, 12, 17, 18, 19, 20 and 21 is set. It follows the status one clock edge after the event.
- R9: A plain write to address 2 with data bit 30 set starts a channel reset. For RST_CYCLES cycles (default 100) chan_rst_o is 1 and bit 30 of address 2 reads 1. Status, arm and irq_o are cleared and events are ignored during this time, and the mask is kept. Bit 30 then clears by itself.
- R10: While rst_ni is low, all status, mask, configuration, irq_o, fatal_o, chan_rst_o and rd_data_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 22 | Event strobes, one per status bit |
| req_addr_i | input | 2 | Register address for reads and writes |
| wr_en_i | input | 1 | Write strobe |
| wr_w1c_i | input | 1 | Write mode: 1 write-one-to-clear, 0 plain |
| wr_data_i | input | 64 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 64 | Read data, valid one cycle after rd_en_i |
| irq_o | output | 1 | Level interrupt |
| fatal_o | output | 1 | Unmasked fatal event pending |
| chan_rst_o | output | 1 | Channel reset in progress |

## Verification
A status bit is visible one edge after its strobe. fatal_o follows at the same edge, and irq_o follows one edge later, because the fire decision is registered. A clear or mask change likewise drops irq_o one edge after the status changes. Reads add one more edge. Every bench step drives its stimulus at a falling edge, lets the capturing edge and the interrupt edge pass, and samples irq_o and fatal_o at the following falling edge. Only then does it issue the read and compare the returned word one edge later. The arm timing and the channel reset length are checked by sampling on each falling edge, so the bench sees irq_o still low after the first edge and high after the second, and counts exactly RST_CYCLES cycles of chan_rst_o.

// File: rtl/rx_evt_pkg.sv
package rx_evt_pkg;
  localparam int NUM_EVT  = 22;
  localparam int DATA_W   = 64;
  localparam int STAT_LSB = 32;
  localparam int ARM_IDX  = 15;
  localparam int RST_BIT  = 30;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd2;

  // events that only a channel reset may clear
  localparam logic [NUM_EVT-1:0] FATAL_SET = 22'h3E1877;
  localparam logic [NUM_EVT-1:0] ARM_BIT   = NUM_EVT'(1) << ARM_IDX;

  typedef enum logic {
    WR_PLAIN = 1'b0,
    WR_W1C   = 1'b1
  } wr_mode_e;
endpackage

// File: rtl/rx_evt_status_bank.sv
module rx_evt_status_bank
  import rx_evt_pkg::*;
#(
  parameter int                  N_EVT   = NUM_EVT,
  parameter int                  ARM_POS = ARM_IDX,
  parameter logic [N_EVT-1:0]    FATAL   = FATAL_SET
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic             clr_all_i,
  input  logic             w1c_en_i,
  input  logic [N_EVT-1:0] w1c_bits_i,
  input  logic             arm_wr_en_i,
  input  logic             arm_wr_val_i,
  input  logic             fire_i,
  output logic [N_EVT-1:0] st_o
);

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    logic bit_q;
    assign st_o[i] = bit_q;

    if (i == ARM_POS) begin : g_arm
      logic unused_arm_in;
      assign unused_arm_in = evt_i[i] ^ w1c_bits_i[i];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          bit_q <= 1'b0;
        else if (clr_all_i)   bit_q <= 1'b0;
        else if (fire_i)      bit_q <= 1'b0;  // one shot: spent on delivery
        else if (arm_wr_en_i) bit_q <= arm_wr_val_i;
      end
    end else if (FATAL[i]) begin : g_fatal
      logic unused_fatal_clr;
      assign unused_fatal_clr = w1c_bits_i[i];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        bit_q <= 1'b0;
        else if (clr_all_i) bit_q <= 1'b0;
        else if (evt_i[i])  bit_q <= 1'b1;
      end
    end else begin : g_soft
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         bit_q <= 1'b0;
        else if (clr_all_i)                  bit_q <= 1'b0;
        else if (evt_i[i])                   bit_q <= 1'b1;  // new event beats clear
        else if (w1c_en_i && w1c_bits_i[i])  bit_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/rx_evt_irq_gen.sv
module rx_evt_irq_gen
  import rx_evt_pkg::*;
#(
  parameter int               N_EVT   = NUM_EVT,
  parameter int               ARM_POS = ARM_IDX,
  parameter logic [N_EVT-1:0] FATAL   = FATAL_SET
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] st_i,
  input  logic [N_EVT-1:0] mask_i,
  input  logic             hold_i,
  output logic             fire_o,
  output logic             irq_o,
  output logic             fatal_o
);
  localparam logic [N_EVT-1:0] ARM_SEL = N_EVT'(1) << ARM_POS;

  logic [N_EVT-1:0] live;
  logic             pending;
  logic             irq_q;

  assign live    = st_i & ~mask_i;
  assign pending = |(live & ~ARM_SEL);
  assign fire_o  = st_i[ARM_POS] & pending & ~hold_i;
  assign fatal_o = |(live & FATAL);
  assign irq_o   = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_q <= 1'b0;
    else if (hold_i)   irq_q <= 1'b0;
    else if (fire_o)   irq_q <= 1'b1;
    else if (!pending) irq_q <= 1'b0;
  end

endmodule

// File: rtl/rx_chan_rst_seq.sv
module rx_chan_rst_seq #(
  parameter int RST_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(RST_CYCLES - 1);
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/rx_evt_intr_ctrl.sv
module rx_evt_intr_ctrl
  import rx_evt_pkg::*;
#(
  parameter int RST_CYCLES = 100
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_EVT-1:0]   evt_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic                 wr_en_i,
  input  logic                 wr_w1c_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 rd_en_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 irq_o,
  output logic                 fatal_o,
  output logic                 chan_rst_o
);

  wr_mode_e             wr_mode;
  logic                 plain_wr, w1c_wr;
  logic                 stat_w1c, stat_plain, mask_wr, rst_start;
  logic                 busy, clr_all, fire;
  logic [NUM_EVT-1:0]   st_q, mask_q;
  logic [DATA_W-1:0]    rd_word;
  logic                 unused_wr_bits;

  assign wr_mode    = wr_mode_e'(wr_w1c_i);
  assign plain_wr   = wr_en_i && (wr_mode == WR_PLAIN);
  assign w1c_wr     = wr_en_i && (wr_mode == WR_W1C);
  assign stat_w1c   = w1c_wr   && (req_addr_i == ADDR_STAT);
  assign stat_plain = plain_wr && (req_addr_i == ADDR_STAT);
  assign mask_wr    = plain_wr && (req_addr_i == ADDR_MASK);
  assign rst_start  = plain_wr && (req_addr_i == ADDR_CFG) && wr_data_i[RST_BIT] && !busy;
  assign clr_all    = busy | rst_start;

  assign unused_wr_bits = ^{wr_data_i[DATA_W-1:STAT_LSB+NUM_EVT],
                            wr_data_i[STAT_LSB-1:RST_BIT+1],
                            wr_data_i[RST_BIT-1:NUM_EVT]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_wr) mask_q <= wr_data_i[NUM_EVT-1:0];
  end

  rx_evt_status_bank #(
    .N_EVT  (NUM_EVT),
    .ARM_POS(ARM_IDX),
    .FATAL  (FATAL_SET)
  ) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_i),
    .clr_all_i   (clr_all),
    .w1c_en_i    (stat_w1c),
    .w1c_bits_i  (wr_data_i[STAT_LSB +: NUM_EVT]),
    .arm_wr_en_i (stat_plain),
    .arm_wr_val_i(wr_data_i[STAT_LSB + ARM_IDX]),
    .fire_i      (fire),
    .st_o        (st_q)
  );

  rx_evt_irq_gen #(
    .N_EVT  (NUM_EVT),
    .ARM_POS(ARM_IDX),
    .FATAL  (FATAL_SET)
  ) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .st_i   (st_q),
    .mask_i (mask_q),
    .hold_i (busy),
    .fire_o (fire),
    .irq_o  (irq_o),
    .fatal_o(fatal_o)
  );

  rx_chan_rst_seq #(
    .RST_CYCLES(RST_CYCLES)
  ) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(rst_start),
    .busy_o (busy)
  );

  always_comb begin
    rd_word = '0;
    unique case (req_addr_i)
      ADDR_STAT: rd_word[STAT_LSB +: NUM_EVT] = st_q;
      ADDR_MASK: rd_word[NUM_EVT-1:0]         = mask_q;
      ADDR_CFG:  rd_word[RST_BIT]             = busy;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= rd_word;
  end

  assign chan_rst_o = busy;

endmodule

// File: rtl/rx_evt_intr_sva.sv
module rx_evt_intr_sva
  import rx_evt_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic [NUM_EVT-1:0] st_q,
  input logic               rst_start,
  input logic               irq_o,
  input logic               chan_rst_o
);
  localparam logic [NUM_EVT-1:0] EVT_SEL = ~ARM_BIT;

  a_r1_event_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chan_rst_o && !rst_start) |=>
      ((st_q & $past(evt_i & EVT_SEL)) == $past(evt_i & EVT_SEL)));

  a_r3_arm_spent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !st_q[ARM_IDX]);

  a_r5_fatal_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chan_rst_o && !rst_start) |=>
      ((st_q & $past(st_q & FATAL_SET)) == $past(st_q & FATAL_SET)));

  a_r9_status_wiped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_o |=> (st_q == '0));

  a_r9_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_rst_o |=> !irq_o);

endmodule

bind rx_evt_intr_ctrl rx_evt_intr_sva u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .evt_i     (evt_i),
  .st_q      (st_q),
  .rst_start (rst_start),
  .irq_o     (irq_o),
  .chan_rst_o(chan_rst_o)
);

// File: tb/test_rx_evt_intr_ctrl.sv
`timescale 1ns/1ps
module test_rx_evt_intr_ctrl;
  localparam int RST_CYC = 100;
  localparam int NV      = 15;
  // op: 0 event, 1 w1c status, 2 plain status (val at 47:32), 3 mask
  // fields: [47:46] op, [45:24] val, [23:2] exp status, [1] irq, [0] fatal
  localparam logic [47:0] VEC [NV] = '{
    {2'd0, 22'h000008, 22'h000008, 1'b0, 1'b0},  // R1
    {2'd2, 22'h008000, 22'h000008, 1'b1, 1'b0},  // R3 arm fires, self-clears
    {2'd0, 22'h000200, 22'h000208, 1'b1, 1'b0},  // R3 stays high
    {2'd1, 22'h000208, 22'h000000, 1'b0, 1'b0},  // R5 clear, irq falls
    {2'd0, 22'h002000, 22'h002000, 1'b0, 1'b0},  // R4 no rearm
    {2'd3, 22'h002000, 22'h002000, 1'b0, 1'b0},  // R2 mask bit 13
    {2'd2, 22'h008000, 22'h00A000, 1'b0, 1'b0},  // R2 masked: arm held
    {2'd3, 22'h000000, 22'h002000, 1'b1, 1'b0},  // R2 unmask fires
    {2'd1, 22'h002000, 22'h000000, 1'b0, 1'b0},  // R5
    {2'd0, 22'h000001, 22'h000001, 1'b0, 1'b1},  // R8 fatal
    {2'd1, 22'h3FFFFF, 22'h000001, 1'b0, 1'b1},  // R5 fatal immune
    {2'd3, 22'h000001, 22'h000001, 1'b0, 1'b0},  // R2 fatal masked
    {2'd3, 22'h000000, 22'h000001, 1'b0, 1'b1},  // R8
    {2'd0, 22'h008000, 22'h000001, 1'b0, 1'b1},  // R1 input 15 ignored
    {2'd2, 22'h008000, 22'h000001, 1'b1, 1'b1}   // R3 fatal counts as event
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [21:0] evt_i = '0;
  logic [1:0]  req_addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wr_w1c_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [63:0] rd_data_o;
  logic        irq_o, fatal_o, chan_rst_o;

  int n_chk = 0;
  int n_err = 0;
  int rst_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rx_evt_intr_ctrl #(.RST_CYCLES(RST_CYC)) i_rx_evt_intr_ctrl (
    .clk_i, .rst_ni, .evt_i, .req_addr_i, .wr_en_i, .wr_w1c_i,
    .wr_data_i, .rd_en_i, .rd_data_o, .irq_o, .fatal_o, .chan_rst_o
  );

  always @(negedge clk_i) if (chan_rst_o) rst_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic w1c, input logic [63:0] d);
    @(negedge clk_i);
    req_addr_i = a; wr_w1c_i = w1c; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_w1c_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic pulse(input logic [21:0] e);
    @(negedge clk_i);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk_i);
    req_addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  function automatic logic [63:0] sw(input logic [21:0] s);
    return {10'b0, s, 32'b0};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk("R10 irq", {63'b0, irq_o}, 64'd0);
    chk("R10 fatal", {63'b0, fatal_o}, 64'd0);
    chk("R10 chan_rst", {63'b0, chan_rst_o}, 64'd0);
    chk("R10 rd_data", rd_data_o, 64'd0);
    rst_ni = 1'b1;
    rd(2'd0, d); chk("R10 status", d, 64'd0);
    rd(2'd1, d); chk("R10 mask", d, 64'd0);
    rd(2'd2, d); chk("R10 cfg", d, 64'd0);
    rd(2'd3, d); chk("R1 addr3 zero", d, 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [21:0] val;
      op  = VEC[i][47:46];
      val = VEC[i][45:24];
      @(negedge clk_i);
      case (op)
        2'd0: evt_i = val;
        2'd1: begin req_addr_i = 2'd0; wr_w1c_i = 1'b1; wr_data_i = sw(val); wr_en_i = 1'b1; end
        2'd2: begin req_addr_i = 2'd0; wr_w1c_i = 1'b0; wr_data_i = sw(val); wr_en_i = 1'b1; end
        default: begin req_addr_i = 2'd1; wr_w1c_i = 1'b0; wr_data_i = {42'b0, val}; wr_en_i = 1'b1; end
      endcase
      @(negedge clk_i);
      evt_i = '0; wr_en_i = 1'b0; wr_w1c_i = 1'b0; wr_data_i = '0;
      @(negedge clk_i);
      chk($sformatf("R3 vec%0d irq", i), {63'b0, irq_o}, {63'b0, VEC[i][1]});
      chk($sformatf("R8 vec%0d fatal", i), {63'b0, fatal_o}, {63'b0, VEC[i][0]});
      rd(2'd0, d);
      chk($sformatf("R1 vec%0d status", i), d, sw(VEC[i][23:2]));
    end

    // R9 channel reset with mask preserved
    wr(2'd1, 1'b0, 64'h0F0F0);
    rst_cnt = 0;
    wr(2'd2, 1'b0, 64'h4000_0000);
    chk("R9 chan_rst high", {63'b0, chan_rst_o}, 64'd1);
    chk("R9 fatal cleared", {63'b0, fatal_o}, 64'd0);
    pulse(22'h000008);
    rd(2'd0, d); chk("R9 status wiped, events ignored", d, 64'd0);
    rd(2'd2, d); chk("R9 cfg bit30", d, 64'h4000_0000);
    chk("R9 irq low", {63'b0, irq_o}, 64'd0);
    while (chan_rst_o && !done) @(negedge clk_i);
    chk("R9 reset length", 64'(rst_cnt), 64'(RST_CYC));
    rd(2'd2, d); chk("R9 bit30 self-clear", d, 64'd0);
    rd(2'd1, d); chk("R9 mask kept", d, 64'h0F0F0);
    wr(2'd1, 1'b0, 64'd0);

    // R7 plain write leaves status bits alone
    pulse(22'h000008);
    wr(2'd0, 1'b0, 64'hFFFF_7FFF_FFFF_FFFF);
    rd(2'd0, d); chk("R7 plain write", d, sw(22'h000008));
    chk("R7 no irq", {63'b0, irq_o}, 64'd0);

    // R3 arm to irq latency
    @(negedge clk_i);
    req_addr_i = 2'd0; wr_data_i = sw(22'h008000); wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_data_i = '0;
    chk("R3 irq not yet", {63'b0, irq_o}, 64'd0);
    @(negedge clk_i);
    chk("R3 irq after fire", {63'b0, irq_o}, 64'd1);
    rd(2'd0, d); chk("R3 arm consumed", d, sw(22'h000008));

    // R4 no second interrupt without rearm
    wr(2'd0, 1'b1, sw(22'h000008));
    @(negedge clk_i);
    chk("R4 irq dropped", {63'b0, irq_o}, 64'd0);
    pulse(22'h000200);
    repeat (3) @(negedge clk_i);
    chk("R4 stays low", {63'b0, irq_o}, 64'd0);

    // R6 event beats same-cycle clear
    pulse(22'h004000);
    rd(2'd0, d); chk("R6 setup", d, sw(22'h004200));
    @(negedge clk_i);
    evt_i = 22'h000200;
    req_addr_i = 2'd0; wr_w1c_i = 1'b1; wr_data_i = sw(22'h004200); wr_en_i = 1'b1;
    @(negedge clk_i);
    evt_i = '0; wr_en_i = 1'b0; wr_w1c_i = 1'b0; wr_data_i = '0;
    rd(2'd0, d); chk("R6 event wins", d, sw(22'h000200));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule